// File: doc/BRIEF.md
# OFDM Symbol Input Capture Buffer

This block gathers one complete block of complex time-domain samples, 2048 by default, ahead of a transform engine. A frame-start strobe marks the first sample. From that point the block stores samples in order into an internal sample memory, which is modelled as a register array. Each entry holds an 8-bit real part and an 8-bit imaginary part, both two's complement. When the last entry of the block is written, the block raises a one-cycle `block_ready` pulse. The transform engine can then read the whole block through a combinational read port.

Samples arrive in one of two transfer formats, selected by `par_mode`. In the interleaved format the real part and then the imaginary part of each sample come on `din` in consecutive cycles. In the parallel format the real part comes on `din_re` and the imaginary part on `din` in the same cycle, and one sample is taken every second clock. Both formats therefore deliver samples at the same rate. The format is latched when the strobe arrives. A new strobe in the middle of a block drops the partial block and starts again at sample 0.

Top module: `ocb_capture_buffer`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low and right after it, `capturing`, `block_ready` and `cap_index` are 0. Reset aborts a capture in progress, and that block never produces `block_ready`.
- R2: A capture starts at the clock edge where `frame_start` is sampled high after having been low, or is the first high sample after reset. `capturing` is 1 from the following cycle.
- R3: With `par_mode` = 0 at the start, `din` carries the real part of sample k in cycle 2k, where the strobe cycle is cycle 0, and its imaginary part in cycle 2k+1. `din_re` is ignored.
- R4: With `par_mode` = 1 at the start, `din_re` (real part) and `din` (imaginary part) are sampled together in cycle 2k for sample k. Values driven in odd cycles are ignored.
- R5: A strobe held high for two cycles gives the same stored block and the same `block_ready` timing as a one-cycle strobe.
- R6: The block is complete once DEPTH samples are stored. `block_ready` is high for exactly one cycle: the cycle after the edge that stores the last sample. That edge is edge 2·DEPTH−1 after the start edge in interleaved format and edge 2·DEPTH−2 in parallel format. `capturing` is 0 in that same cycle.
- R7: A new strobe rising edge while a block is partly captured restarts capture at sample 0. No `block_ready` is produced for the abandoned samples.
- R8: The format chosen at the start edge holds for the whole block. Changes on `par_mode` during capture have no effect.
- R9: `rd_re` and `rd_im` combinationally show the real and imaginary parts stored at `rd_addr`, bit for bit as received.
- R10: `cap_index` gives the number of samples already stored in the current block. It counts up by one with each stored sample.
- R11: While idle and with no strobe, input data are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| par_mode | input | 1 | Transfer format: 0 interleaved on `din`, 1 parallel buses |
| din | input | DATA_W | Real then imaginary part (interleaved), or imaginary part (parallel) |
| din_re | input | DATA_W | Real part in parallel format |
| frame_start | input | 1 | Start strobe, 1 or 2 cycles, aligned with the first real part |
| rd_addr | input | log2(DEPTH) | Read address of the sample memory |
| rd_re | output | DATA_W | Stored real part at `rd_addr` |
| rd_im | output | DATA_W | Stored imaginary part at `rd_addr` |
| block_ready | output | 1 | One-cycle pulse when a full block is stored |
| capturing | output | 1 | 1 while a block is being filled, 0 when idle |
| cap_index | output | log2(DEPTH) | Samples stored so far in the current block |

## Verification
The sample values are distinct functions of the sample index, so a slip of one cycle or a swap of real and imaginary parts shows up in the read-back. In interleaved format, random values on `din_re` show whether that bus leaks into the data. In parallel format, random values on both buses in the off cycles show whether the phase is wrong. Each format is also run with a two-cycle strobe, which separates edge detection from level detection. A restart after a partial block, a format change during capture and a reset during capture each show whether the index and phase state clears correctly.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_FILL = 1'b1
   } cap_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ocb_start_detect.sv
module ocb_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   output logic start_pulse
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= frame_start;
   end

   // only the first high cycle of a strobe counts
   assign start_pulse = frame_start & ~strobe_q;
endmodule

// File: rtl/ocb_sequencer.sv
module ocb_sequencer
   import ocb_pkg::*;
#(
   parameter int DEPTH = 2048
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       par_in,
   output logic                       wr_en,
   output logic [$clog2(DEPTH)-1:0]   wr_addr,
   output logic                       hold_en,
   output logic                       eff_par,
   output logic                       mode_q,
   output logic                       capturing,
   output logic [$clog2(DEPTH)-1:0]   idx_out,
   output logic                       done
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   cap_state_e       state_q;
   logic             phase_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             eff_phase;
   logic             active;
   logic             last;

   // in the strobe cycle the live mode and phase 0 apply
   always_comb begin
      eff_par   = start ? par_in : mode_q;
      eff_phase = start ? 1'b0 : phase_q;
      active    = start | (state_q == CAP_FILL);
      wr_en     = active & (eff_par ? ~eff_phase : eff_phase);
      hold_en   = active & ~eff_par & ~eff_phase;
      wr_addr   = start ? '0 : idx_q;
      last      = wr_en & (wr_addr == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CAP_IDLE;
         phase_q <= 1'b0;
         idx_q   <= '0;
         mode_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last & ~start;
         if (start) begin
            state_q <= CAP_FILL;
            mode_q  <= par_in;
            phase_q <= 1'b1;
            idx_q   <= wr_en ? IDX_W'(1) : '0;
         end else if (state_q == CAP_FILL) begin
            phase_q <= ~phase_q;
            if (wr_en) begin
               if (last) begin
                  state_q <= CAP_IDLE;
                  phase_q <= 1'b0;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
         end
      end
   end

   assign capturing = (state_q == CAP_FILL);
   assign idx_out   = idx_q;
   assign done      = done_q;
endmodule

// File: rtl/ocb_sample_pack.sv
module ocb_sample_pack #(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_en,
   input  logic                eff_par,
   input  logic [DATA_W-1:0]   din,
   input  logic [DATA_W-1:0]   din_re,
   output logic [2*DATA_W-1:0] word
);
   logic [DATA_W-1:0] re_hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       re_hold_q <= '0;
      else if (hold_en) re_hold_q <= din;
   end

   // upper half real, lower half imaginary
   assign word = eff_par ? {din_re, din} : {re_hold_q, din};
endmodule

// File: rtl/ocb_sample_store.sv
module ocb_sample_store #(
   parameter int DEPTH  = 2048,
   parameter int WORD_W = 16
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [$clog2(DEPTH)-1:0]  wr_addr,
   input  logic [WORD_W-1:0]         wr_word,
   input  logic [$clog2(DEPTH)-1:0]  rd_addr,
   output logic [WORD_W-1:0]         rd_word
);
   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_word;
   end

   assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/ocb_capture_buffer.sv
module ocb_capture_buffer
   import ocb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2048
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      par_mode,
   input  logic [DATA_W-1:0]         din,
   input  logic [DATA_W-1:0]         din_re,
   input  logic                      frame_start,
   input  logic [$clog2(DEPTH)-1:0]  rd_addr,
   output logic [DATA_W-1:0]         rd_re,
   output logic [DATA_W-1:0]         rd_im,
   output logic                      block_ready,
   output logic                      capturing,
   output logic [$clog2(DEPTH)-1:0]  cap_index
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int WORD_W = 2 * DATA_W;

   generate
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("ocb_capture_buffer: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("ocb_capture_buffer: DATA_W must be positive");
      end
   endgenerate

   logic              start_pulse;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_addr;
   logic              hold_en;
   logic              eff_par;
   logic              mode_q;
   logic [WORD_W-1:0] wr_word;
   logic [WORD_W-1:0] rd_word;

   ocb_start_detect u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .start_pulse (start_pulse)
   );

   ocb_sequencer #(.DEPTH(DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_pulse),
      .par_in    (par_mode),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .hold_en   (hold_en),
      .eff_par   (eff_par),
      .mode_q    (mode_q),
      .capturing (capturing),
      .idx_out   (cap_index),
      .done      (block_ready)
   );

   ocb_sample_pack #(.DATA_W(DATA_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold_en (hold_en),
      .eff_par (eff_par),
      .din     (din),
      .din_re  (din_re),
      .word    (wr_word)
   );

   ocb_sample_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_word (wr_word),
      .rd_addr (rd_addr),
      .rd_word (rd_word)
   );

   assign rd_re = rd_word[WORD_W-1:DATA_W];
   assign rd_im = rd_word[DATA_W-1:0];
endmodule

// File: rtl/ocb_capture_buffer_chk.sv
module ocb_capture_buffer_chk #(
   parameter int IDX_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             start,
   input logic             wr_en,
   input logic             mode_q,
   input logic             capturing,
   input logic             block_ready,
   input logic [IDX_W-1:0] cap_index
);
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!capturing && !block_ready && cap_index == '0));

   assert_start_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_start) |=> capturing);

   assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      block_ready |=> !block_ready);

   assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      block_ready |-> !capturing);

   assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (capturing && $past(capturing) && !start) |-> $stable(mode_q));

   assert_index_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      capturing |=> (cap_index == $past(cap_index)
                  || cap_index == $past(cap_index) + IDX_W'(1)
                  || cap_index == '0));

   assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!capturing && !start) |-> !wr_en);
endmodule

bind ocb_capture_buffer ocb_capture_buffer_chk #(.IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .start       (start_pulse),
   .wr_en       (wr_en),
   .mode_q      (mode_q),
   .capturing   (capturing),
   .block_ready (block_ready),
   .cap_index   (cap_index)
);

// File: tb/ocb_capture_buffer_bench.sv
module ocb_capture_buffer_bench;
   localparam int D  = 2048;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          par_mode = 1'b0;
   logic [7:0]    din = '0;
   logic [7:0]    din_re = '0;
   logic          frame_start = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_re, rd_im;
   logic          block_ready, capturing;
   logic [AW-1:0] cap_index;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   ocb_capture_buffer u_ocb_capture_buffer (
      .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .din(din), .din_re(din_re),
      .frame_start(frame_start), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
      .block_ready(block_ready), .capturing(capturing), .cap_index(cap_index)
   );

   function automatic logic [7:0] re_of(input int s, input int k);
      return 8'((k * 3 + s) & 255);
   endfunction

   function automatic logic [7:0] im_of(input int s, input int k);
      return 8'((k * 7 + s * 5 + 1) & 255);
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drives ncyc cycles from a negedge; cycle 0 is the strobe cycle
   task automatic drive_block(input bit par, input int s, input int slen, input int ncyc,
                              input int flip_at, output int ready_at, output int n_ready,
                              output int idx9, output int cap5);
      ready_at = -1; n_ready = 0; idx9 = -1; cap5 = -1;
      for (int c = 0; c < ncyc; c++) begin
         int k = c / 2;
         par_mode    = (flip_at >= 0 && c >= flip_at) ? ~par : par;
         frame_start = (c < slen);
         if (k >= D) begin
            din = 8'($urandom); din_re = 8'($urandom);
         end else if (par) begin
            if (c % 2 == 0) begin din_re = re_of(s, k); din = im_of(s, k); end
            else begin din_re = 8'($urandom); din = 8'($urandom); end
         end else begin
            din    = (c % 2 == 0) ? re_of(s, k) : im_of(s, k);
            din_re = 8'($urandom);
         end
         @(negedge clk);
         if (block_ready) begin
            n_ready++;
            if (ready_at < 0) ready_at = c;
         end
         if (c == 9) idx9 = int'(cap_index);
         if (c == 5) cap5 = int'(capturing);
      end
      frame_start = 1'b0;
   endtask

   task automatic check_mem(input int s, input string req);
      int bad = 0;
      int first = -1;
      for (int a = 0; a < D; a++) begin
         rd_addr = AW'(a);
         #1;
         if (rd_re !== re_of(s, a) || rd_im !== im_of(s, a)) begin
            bad++;
            if (first < 0) first = a;
         end
      end
      if (first >= 0)
         $display("note: first wrong entry %0d for %s", first, req);
      chk(req, "mismatching memory entries", bad, 0);
   endtask

   task automatic idle(input int n);
      frame_start = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "capturing in reset", int'(capturing), 0);
      chk("R1", "block_ready in reset", int'(block_ready), 0);
      chk("R1", "cap_index in reset", int'(cap_index), 0);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic t_mux_basic;
      int ra, nr, i9, c5;
      drive_block(1'b0, 11, 1, 2 * D + 3, -1, ra, nr, i9, c5);
      chk("R2", "capturing after strobe (interleaved)", c5, 1);
      chk("R10", "cap_index after 10 edges (interleaved)", i9, 5);
      chk("R6", "ready cycle (interleaved)", ra, 2 * D - 1);
      chk("R6", "ready pulse count (interleaved)", nr, 1);
      chk("R6", "capturing after block", int'(capturing), 0);
      check_mem(11, "R3 R9 R11 interleaved");
   endtask

   task automatic t_par_basic;
      int ra, nr, i9, c5;
      drive_block(1'b1, 40, 1, 2 * D + 3, -1, ra, nr, i9, c5);
      chk("R2", "capturing after strobe (parallel)", c5, 1);
      chk("R10", "cap_index after 10 edges (parallel)", i9, 5);
      chk("R6", "ready cycle (parallel)", ra, 2 * D - 2);
      chk("R6", "ready pulse count (parallel)", nr, 1);
      check_mem(40, "R4 R9 parallel");
   endtask

   task automatic t_long_strobe;
      int ra, nr, i9, c5;
      drive_block(1'b0, 77, 2, 2 * D + 3, -1, ra, nr, i9, c5);
      chk("R5", "ready cycle, 2-cycle strobe interleaved", ra, 2 * D - 1);
      chk("R5", "ready count, 2-cycle strobe interleaved", nr, 1);
      check_mem(77, "R5 interleaved");
      idle(3);
      drive_block(1'b1, 90, 2, 2 * D + 3, -1, ra, nr, i9, c5);
      chk("R5", "ready cycle, 2-cycle strobe parallel", ra, 2 * D - 2);
      chk("R5", "cap_index, 2-cycle strobe parallel", i9, 5);
      check_mem(90, "R5 parallel");
   endtask

   task automatic t_restart;
      int ra, nr, i9, c5;
      drive_block(1'b0, 3, 1, 301, -1, ra, nr, i9, c5);
      chk("R7", "no ready on partial block", nr, 0);
      drive_block(1'b0, 123, 1, 2 * D + 3, -1, ra, nr, i9, c5);
      chk("R7", "ready cycle after restart", ra, 2 * D - 1);
      chk("R7", "ready count after restart", nr, 1);
      check_mem(123, "R7 restart");
   endtask

   task automatic t_mode_hold;
      int ra, nr, i9, c5;
      drive_block(1'b1, 55, 1, 2 * D + 3, 100, ra, nr, i9, c5);
      chk("R8", "ready cycle with par_mode flipped", ra, 2 * D - 2);
      check_mem(55, "R8 mode held");
      par_mode = 1'b0;
      idle(3);
   endtask

   task automatic t_abort;
      int ra, nr, i9, c5;
      int seen = 0;
      drive_block(1'b0, 7, 1, 300, -1, ra, nr, i9, c5);
      rst_n = 1'b0;
      idle(2);
      chk("R1", "capturing after mid-block reset", int'(capturing), 0);
      chk("R1", "cap_index after mid-block reset", int'(cap_index), 0);
      rst_n = 1'b1;
      for (int c = 0; c < 2 * D + 10; c++) begin
         din = 8'($urandom); din_re = 8'($urandom);
         @(negedge clk);
         if (block_ready) seen++;
         if (capturing) seen++;
      end
      chk("R1", "activity after aborted block", seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_mux_basic();
      idle(3);
      t_par_basic();
      idle(3);
      t_long_strobe();
      idle(3);
      t_restart();
      idle(3);
      t_mode_hold();
      t_abort();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule